// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Sequencer

This block decides when a processor core may execute and which clock it runs from after a power-on, a reset or a wake from sleep. When the primary source is a crystal or resonator, the oscillator needs time to settle. If two-speed start-up is enabled and the source-select field chooses the primary clock, the core starts at once on the slow internal RC clock. Meanwhile a start-up timer counts edges of the primary oscillator. Once the timer finishes, the block asks the clock multiplexer to switch to the primary source and raises the oscillator-stable flag. If two-speed start-up is disabled, the core is held until the timer finishes, and the select request stays on the primary clock the whole time.

The start-up timer runs in the primary clock domain. Its enable crosses into that domain, and its done flag crosses back into the internal RC domain, each through a two-stage synchronizer. Primary modes that are not crystals need no settling time, so they skip the timer. A sleep request or a reset clears any partial count, and the next trigger starts the full count again. All pins are plain control and status levels or one-cycle pulses. There is no streaming interface, so there is no back-pressure.

Top module: `twospd_startup_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `core_run` and `osc_stable` are 0.
- R2: With `pri_mode` a crystal code (3'b000 low-power crystal, 3'b001 standard crystal, 3'b010 high-speed crystal), `src_sel` = 2'b00 and `two_spd_en` = 1, `core_run` is 1 within 10 RC cycles of a trigger, and `clk_sel_pri` stays 0 until `osc_stable` is 1.
- R3: In a crystal mode, the start-up timer must see CNT_MAIN + CNT_EXTRA = 1024 + 8 = 1032 primary clock edges after it is enabled. Only after that, and after the two-flop crossing back to the RC domain, does `osc_stable` rise. So it never rises earlier than 1032 primary periods after the trigger.
- R4: When the timer completes with `src_sel` = 2'b00, `osc_stable` and `clk_sel_pri` are both 1 and `core_run` stays 1.
- R5: With a crystal mode, `src_sel` = 2'b00 and `two_spd_en` = 0, `core_run` is 0 until `osc_stable` is 1. `clk_sel_pri` stays 1 throughout, so no clock switch occurs.
- R6: With a non-crystal `pri_mode` (3'b011 to 3'b111), no timer runs. Within 10 RC cycles of a trigger, `osc_stable` and `core_run` are 1, and `clk_sel_pri` is 1 when `src_sel` = 2'b00.
- R7: With `src_sel` not 2'b00, `clk_sel_pri` stays 0 and `core_run` is not held. In a crystal mode the timer still sets `osc_stable` when it completes.
- R8: A one-cycle `sleep_req` pulse while awake makes `core_run` and `osc_stable` 0 from the next RC edge on.
- R9: While asleep, a one-cycle pulse on `wake_irq` or `wake_wdt` restarts the sequence from zero, as after a reset. While awake and stable, wake pulses change nothing.
- R10: A sleep request or a reset during counting discards the partial count. After the next trigger, all 1032 edges are counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC clock; core-side domain |
| pri_clk | input | 1 | Primary oscillator clock; start-up timer domain |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or other reset) |
| sleep_req | input | 1 | One-cycle pulse (rc_clk): core enters sleep |
| wake_irq | input | 1 | One-cycle pulse (rc_clk): wake caused by an interrupt |
| wake_wdt | input | 1 | One-cycle pulse (rc_clk): wake caused by a watchdog time-out |
| pri_mode | input | 3 | Configured primary mode; 000/001/010 are crystal types |
| src_sel | input | 2 | System clock source-select field; 00 chooses the primary path |
| two_spd_en | input | 1 | Two-speed start-up enable |
| clk_sel_pri | output | 1 | 1 requests the primary clock, 0 the internal RC clock |
| osc_stable | output | 1 | Primary oscillator start-up timer has completed |
| core_run | output | 1 | 1 lets the core execute, 0 holds it |

## Verification
The hardest case to reach from the ports is a sleep request arriving partway through a count, followed by a wake. If the partial count were kept, the outputs would look almost the same. The bench sleeps about 300 RC cycles into a count, wakes about 20 cycles later, and checks that `clk_sel_pri` is still 0 at 600 cycles after the wake. That point is well past when the original count would have ended. An early reset during counting is covered the same way. Ordinary wakes after a completed run are also tested, and they only pass if the synchronized done flag has been seen to clear before counting restarts.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam logic [2:0] MODE_XTAL_LO  = 3'd0;
  localparam logic [2:0] MODE_XTAL_MID = 3'd1;
  localparam logic [2:0] MODE_XTAL_HI  = 3'd2;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_DRAIN = 3'd1,
    ST_COUNT = 3'd2,
    ST_RUN   = 3'd3,
    ST_SLEEP = 3'd4
  } tss_state_e;

  function automatic logic is_crystal(input logic [2:0] mode);
    return (mode == MODE_XTAL_LO) || (mode == MODE_XTAL_MID) || (mode == MODE_XTAL_HI);
  endfunction
endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tss_ost_counter.sv
module tss_ost_counter #(
  parameter int CNT_MAIN  = 1024,
  parameter int CNT_EXTRA = 8
) (
  input  logic pri_clk,
  input  logic rst_pri_n,
  input  logic en_i,
  output logic done_o
);
  localparam int TOTAL = CNT_MAIN + CNT_EXTRA;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge pri_clk or negedge rst_pri_n) begin
    if (!rst_pri_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
        cnt_q  <= CW'(TOTAL);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = done_q;

  // R3
  done_after_full_count_chk: assert property (@(posedge pri_clk) disable iff (!rst_pri_n)
    $rose(done_q) |-> ($past(cnt_q) == LAST && $past(en_i)));

  // R10
  count_cleared_when_off_chk: assert property (@(posedge pri_clk) disable iff (!rst_pri_n)
    !en_i |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic rc_clk,
  input  logic rst_rc_n,
  input  logic sleep_req_i,
  input  logic wake_i,
  input  logic crystal_i,
  input  logic src_pri_i,
  input  logic two_spd_en_i,
  input  logic done_i,
  output logic cnt_en_o,
  output logic clk_sel_pri_o,
  output logic osc_stable_o,
  output logic core_run_o
);
  tss_state_e state_q, state_d;
  logic       cnt_en_q;
  logic       awake;
  logic       fast_start;

  assign awake      = (state_q == ST_DRAIN) || (state_q == ST_COUNT) || (state_q == ST_RUN);
  assign fast_start = two_spd_en_i && crystal_i && src_pri_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT:  state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (sleep_req_i)     state_d = ST_SLEEP;
        else if (!crystal_i) state_d = ST_RUN;
        else if (!done_i)    state_d = ST_COUNT;
      end
      ST_COUNT: begin
        if (sleep_req_i)     state_d = ST_SLEEP;
        else if (done_i)     state_d = ST_RUN;
      end
      ST_RUN: begin
        if (sleep_req_i)     state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_i)          state_d = ST_DRAIN;
      end
      default:               state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge rc_clk or negedge rst_rc_n) begin
    if (!rst_rc_n) begin
      state_q  <= ST_BOOT;
      cnt_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_en_q <= (state_d == ST_COUNT);
    end
  end

  assign cnt_en_o      = cnt_en_q;
  assign osc_stable_o  = (state_q == ST_RUN);
  assign clk_sel_pri_o = src_pri_i && !(fast_start && state_q != ST_RUN);
  assign core_run_o    = (state_q == ST_RUN) ||
                         (((state_q == ST_DRAIN) || (state_q == ST_COUNT)) &&
                          (two_spd_en_i || !src_pri_i));

  // R3
  stable_needs_done_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    ($rose(osc_stable_o) && crystal_i) |-> $past(done_i));

  // R5
  hold_until_stable_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    (!two_spd_en_i && src_pri_i && crystal_i && !osc_stable_o) |-> !core_run_o);

  // R8
  sleep_drops_run_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    (sleep_req_i && awake) |=> (!core_run_o && !osc_stable_o));

  // R9
  wake_ignored_awake_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    (state_q == ST_RUN && !sleep_req_i) |=> osc_stable_o);
endmodule

// File: rtl/twospd_startup_seq.sv
module twospd_startup_seq
  import tss_pkg::*;
#(
  parameter int CNT_MAIN    = 1024,
  parameter int CNT_EXTRA   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       rc_clk,
  input  logic       pri_clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       wake_irq,
  input  logic       wake_wdt,
  input  logic [2:0] pri_mode,
  input  logic [1:0] src_sel,
  input  logic       two_spd_en,
  output logic       clk_sel_pri,
  output logic       osc_stable,
  output logic       core_run
);
  logic rst_rc_n, rst_pri_n;
  logic cnt_en_rc, cnt_en_pri;
  logic done_pri, done_rc;
  logic crystal, src_pri, wake;

  assign crystal = is_crystal(pri_mode);
  assign src_pri = (src_sel == 2'b00);
  assign wake    = wake_irq || wake_wdt;

  tss_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_rc (
    .clk(rc_clk), .rst_n(rst_n), .d(1'b1), .q(rst_rc_n));

  tss_sync #(.STAGES(SYNC_STAGES), .W(1)) u_rst_pri (
    .clk(pri_clk), .rst_n(rst_n), .d(1'b1), .q(rst_pri_n));

  tss_sync #(.STAGES(SYNC_STAGES), .W(1)) u_en_to_pri (
    .clk(pri_clk), .rst_n(rst_pri_n), .d(cnt_en_rc), .q(cnt_en_pri));

  tss_ost_counter #(.CNT_MAIN(CNT_MAIN), .CNT_EXTRA(CNT_EXTRA)) u_ost (
    .pri_clk(pri_clk), .rst_pri_n(rst_pri_n), .en_i(cnt_en_pri), .done_o(done_pri));

  tss_sync #(.STAGES(SYNC_STAGES), .W(1)) u_done_to_rc (
    .clk(rc_clk), .rst_n(rst_rc_n), .d(done_pri), .q(done_rc));

  tss_ctrl u_ctrl (
    .rc_clk(rc_clk), .rst_rc_n(rst_rc_n), .sleep_req_i(sleep_req), .wake_i(wake),
    .crystal_i(crystal), .src_pri_i(src_pri), .two_spd_en_i(two_spd_en),
    .done_i(done_rc), .cnt_en_o(cnt_en_rc), .clk_sel_pri_o(clk_sel_pri),
    .osc_stable_o(osc_stable), .core_run_o(core_run));

  // R1
  reset_holds_core_chk: assert property (@(posedge rc_clk)
    !rst_n |-> (!core_run && !osc_stable));

  // R2
  switch_only_when_stable_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    ($rose(clk_sel_pri) && $stable(src_sel) && $stable(two_spd_en) && $stable(pri_mode))
      |-> osc_stable);

  // R7
  alt_source_no_primary_chk: assert property (@(posedge rc_clk) disable iff (!rst_rc_n)
    (src_sel != 2'b00) |-> !clk_sel_pri);
endmodule

// File: tb/twospd_startup_seq_bench.sv
`timescale 1ns/1ps
module twospd_startup_seq_bench;
  logic       rc_clk = 1'b0;
  logic       pri_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_req = 1'b0;
  logic       wake_irq = 1'b0;
  logic       wake_wdt = 1'b0;
  logic [2:0] pri_mode = 3'd1;
  logic [1:0] src_sel = 2'b00;
  logic       two_spd_en = 1'b1;
  logic       clk_sel_pri, osc_stable, core_run;
  int         errors = 0;
  int         checks = 0;

  always #5 rc_clk  = ~rc_clk;   // 100 MHz internal RC stand-in
  always #3 pri_clk = ~pri_clk;  // primary oscillator, 6 ns period

  twospd_startup_seq u_twospd_startup_seq (
    .rc_clk(rc_clk), .pri_clk(pri_clk), .rst_n(rst_n), .sleep_req(sleep_req),
    .wake_irq(wake_irq), .wake_wdt(wake_wdt), .pri_mode(pri_mode), .src_sel(src_sel),
    .two_spd_en(two_spd_en), .clk_sel_pri(clk_sel_pri), .osc_stable(osc_stable),
    .core_run(core_run));

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_rc(input int n);
    repeat (n) @(negedge rc_clk);
  endtask

  task automatic do_reset(input logic [2:0] mode, input logic [1:0] sel, input logic en);
    @(negedge rc_clk);
    rst_n = 1'b0;
    pri_mode = mode;
    src_sel = sel;
    two_spd_en = en;
    wait_rc(4);
    check("R1 core_run in reset", core_run, 1'b0);
    check("R1 osc_stable in reset", osc_stable, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic pulse_sleep();
    @(negedge rc_clk);
    sleep_req = 1'b1;
    @(negedge rc_clk);
    sleep_req = 1'b0;
  endtask

  task automatic t_twospeed_por();
    do_reset(3'd1, 2'b00, 1'b1);
    wait_rc(10);
    check("R2 early run", core_run, 1'b1);
    check("R2 rc selected", clk_sel_pri, 1'b0);
    wait_rc(590);
    check("R3 not stable before 1032 edges", osc_stable, 1'b0);
    check("R2 no switch before stable", clk_sel_pri, 1'b0);
    wait_rc(60);
    check("R3 stable after count", osc_stable, 1'b1);
    check("R4 primary selected", clk_sel_pri, 1'b1);
    check("R4 still running", core_run, 1'b1);
  endtask

  task automatic t_disabled();
    do_reset(3'd2, 2'b00, 1'b0);
    wait_rc(10);
    check("R5 held early", core_run, 1'b0);
    check("R5 primary kept", clk_sel_pri, 1'b1);
    wait_rc(590);
    check("R5 held before stable", core_run, 1'b0);
    wait_rc(60);
    check("R5 runs when stable", core_run, 1'b1);
    check("R5 stable", osc_stable, 1'b1);
    check("R5 primary kept after", clk_sel_pri, 1'b1);
  endtask

  task automatic t_noncrystal();
    do_reset(3'd4, 2'b00, 1'b1);
    wait_rc(10);
    check("R6 stable immediately", osc_stable, 1'b1);
    check("R6 run immediately", core_run, 1'b1);
    check("R6 primary selected", clk_sel_pri, 1'b1);
    do_reset(3'd3, 2'b00, 1'b0);
    wait_rc(10);
    check("R6 no hold without timer", core_run, 1'b1);
  endtask

  task automatic t_altsrc();
    do_reset(3'd0, 2'b01, 1'b1);
    wait_rc(10);
    check("R7 core runs on alt source", core_run, 1'b1);
    check("R7 no primary request", clk_sel_pri, 1'b0);
    wait_rc(650);
    check("R7 timer still completes", osc_stable, 1'b1);
    check("R7 no primary request after", clk_sel_pri, 1'b0);
  endtask

  task automatic t_sleep_wake();
    t_twospeed_por();
    pulse_sleep();
    check("R8 core stops", core_run, 1'b0);
    check("R8 stable cleared", osc_stable, 1'b0);
    check("R8 rc selected in sleep", clk_sel_pri, 1'b0);
    wait_rc(50);
    check("R9 stays asleep without wake", core_run, 1'b0);
    @(negedge rc_clk);
    wake_wdt = 1'b1;
    @(negedge rc_clk);
    wake_wdt = 1'b0;
    wait_rc(10);
    check("R9 runs after watchdog wake", core_run, 1'b1);
    check("R9 rc after wake", clk_sel_pri, 1'b0);
    wait_rc(590);
    check("R9 full recount", osc_stable, 1'b0);
    wait_rc(60);
    check("R9 stable after recount", osc_stable, 1'b1);
    check("R9 primary after recount", clk_sel_pri, 1'b1);
    @(negedge rc_clk);
    wake_irq = 1'b1;
    @(negedge rc_clk);
    wake_irq = 1'b0;
    wait_rc(5);
    check("R9 wake ignored while awake", osc_stable, 1'b1);
    check("R9 select unchanged by wake", clk_sel_pri, 1'b1);
  endtask

  task automatic t_sleep_midcount();
    do_reset(3'd1, 2'b00, 1'b1);
    wait_rc(300);
    pulse_sleep();
    check("R8 sleep mid-count", core_run, 1'b0);
    wait_rc(20);
    @(negedge rc_clk);
    wake_irq = 1'b1;
    @(negedge rc_clk);
    wake_irq = 1'b0;
    wait_rc(600);
    check("R10 partial count discarded (stable)", osc_stable, 1'b0);
    check("R10 partial count discarded (select)", clk_sel_pri, 1'b0);
    wait_rc(60);
    check("R10 stable after full recount", osc_stable, 1'b1);
  endtask

  task automatic t_reset_midcount();
    do_reset(3'd2, 2'b00, 1'b1);
    wait_rc(300);
    do_reset(3'd2, 2'b00, 1'b1);
    wait_rc(600);
    check("R10 reset discards count", osc_stable, 1'b0);
    wait_rc(60);
    check("R10 stable after reset recount", osc_stable, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge rc_clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_twospeed_por();
    t_disabled();
    t_noncrystal();
    t_altsrc();
    t_sleep_wake();
    t_sleep_midcount();
    t_reset_midcount();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule